// File: doc/BRIEF.md
# Half-Duplex SPI Command Engine

A memory-mapped SPI host that runs exactly one flash-style command each time software asks for it. Software programs a command byte into a dedicated register, sets a transmit count and a receive count, and fills a byte-addressed data buffer with the outgoing payload. It then sets an execute bit in the control word. The engine pulls one of four active-low selects low, shifts the command byte and then the payload out on MOSI, and finally clocks in the requested number of reply bytes from MISO.

Replies land in the same buffer, right behind the last payload byte, so one buffer read after the command gives both what was sent and what came back. The transfer is strictly one direction at a time. A busy flag in the control word covers the whole command and the idle gap that follows it. The serial clock is SPI mode 0: it idles low, data is sampled while it is high, and bytes go most significant bit first. Its rate is a fixed division of the system clock.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset every select line is high, SCLK and MOSI are low, and the busy flag, counts, command byte and buffer all read 0.
- R2: Writing a byte with bit 0 set to address 0x02 (bit 16 of the control word) starts a command. That bit reads 1 for one cycle and then 0 once the command is taken. The busy flag (address 0x03 bit 7, control bit 31) reads 1 from the cycle after the write until the command and its trailing gap are over.
- R3: The command byte from address 0x44 goes out first, followed by buffer bytes 0 upward, most significant bit first. Each bit lasts DIV system cycles: SCLK is low for the first half and high for the second. MOSI changes only while SCLK is low.
- R4: After the transmit phase, each reply bit is sampled from MISO while SCLK is high. Reply byte k is written to buffer position tx+k. MOSI stays low during this phase, and MISO is ignored while bytes are being sent.
- R5: Address 0x1D bits [1:0] select which of the four lines goes low. The choice is latched when the command starts, so a later write has no effect on the running command. Only that line is low, and it stays low without a break for the whole command.
- R6: With a receive count of 0, the command ends right after the last bit of the last transmit byte.
- R7: An execute write made while busy reads 1 is ignored: no second command follows.
- R8: Effective counts are tx_eff = min(tx, 70) and rx_eff = min(rx, 70 - tx_eff). No buffer position beyond 69 is ever read or written.
- R9: Between commands all select lines stay high for at least DIV cycles. Busy remains 1 during this gap.
- R10: Writing bit 4 to address 0x02 (bit 20 of the control word) resets the internal buffer pointer. It always reads back 0, and it does not start a command.
- R11: Transmit count (0x48), receive count (0x4B), command byte (0x44) and select field (0x1D) read back the values written. The buffer sits at 0x80 to 0xC5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte (combinational from bus_addr) |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low select lines |

## Verification
The bench aims at the transition from send to receive. A design that put replies at buffer position 0 would overwrite the payload, and one that sampled MISO during sending would corrupt the first reply bits. A command with 68 payload bytes and 5 requested reply bytes checks the clamp; an engine without it would write past position 69 or run extra byte times, which shows up as a longer select window. Mid-command writes of execute and of the select field check that busy requests are dropped and that the select is latched. Commands issued back to back check that the idle gap is kept and that busy covers it.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_GAP  = 2'd2
    } seq_state_e;

    // byte addresses seen by software
    localparam logic [7:0] A_CTRL_EXEC = 8'h02;  // control bits 23:16
    localparam logic [7:0] A_CTRL_STAT = 8'h03;  // control bits 31:24
    localparam logic [7:0] A_CS_SEL    = 8'h1D;
    localparam logic [7:0] A_OPCODE    = 8'h44;
    localparam logic [7:0] A_TX_CNT    = 8'h48;
    localparam logic [7:0] A_RX_CNT    = 8'h4B;
    localparam logic [7:0] A_BUF_BASE  = 8'h80;

endpackage

// File: rtl/spi_sclk_phase.sv
module spi_sclk_phase #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic sclk,
    output logic sample,
    output logic bit_end
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);
    localparam logic [PW-1:0] HALF = PW'(DIV / 2);

    logic [PW-1:0] ph_d, ph_q;

    always_comb begin
        ph_d = '0;
        if (en && ph_q != LAST) ph_d = ph_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign sclk    = en && (ph_q >= HALF);
    assign sample  = en && (ph_q == HALF);
    assign bit_end = en && (ph_q == LAST);

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic       load_tx,
    input  logic       sample,
    input  logic       bit_end,
    input  logic       miso,
    output logic       mosi,
    output logic [7:0] data
);
    typedef struct packed {
        logic [7:0] sh;
        logic       tx;
    } shf_t;

    shf_t d, q;

    always_comb begin
        d = q;
        if (load) begin
            d.sh = load_val;
            d.tx = load_tx;
        end else if (sample && !q.tx) begin
            d.sh = {q.sh[6:0], miso};
        end else if (bit_end && q.tx) begin
            d.sh = {q.sh[6:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mosi = q.tx & q.sh[7];
    assign data = q.sh;

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int DIV   = 4,
    parameter int DEPTH = 70,
    parameter int NCS   = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_we,
    input  logic [7:0]     bus_addr,
    input  logic [7:0]     bus_wdata,
    output logic [7:0]     bus_rdata,
    output logic           sclk,
    output logic           mosi,
    input  logic           miso,
    output logic [NCS-1:0] cs_n
);
    localparam int CW = (NCS > 1) ? $clog2(NCS) : 1;
    localparam int GW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int AW = $clog2(DEPTH);
    localparam logic [7:0] DEPTH8  = 8'(DEPTH);
    localparam logic [8:0] BUF_END = {1'b0, A_BUF_BASE} + 9'(DEPTH);

    typedef struct packed {
        seq_state_e    st;
        logic          exec;
        logic [CW-1:0] csel;
        logic [CW-1:0] cs_lat;
        logic [7:0]    opc;
        logic [7:0]    txc;
        logic [7:0]    rxc;
        logic [7:0]    tx_eff;
        logic [7:0]    last;
        logic [7:0]    idx;
        logic [2:0]    bitn;
        logic [GW-1:0] gap;
    } eng_t;

    eng_t d, q;
    logic [7:0]    mem_q [DEPTH];
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [7:0]    mem_wdata;
    logic          ld, ld_tx;
    logic [7:0]    ld_val;
    logic          busy, exec_pend;
    logic          ph_sclk, ph_sample, ph_bit_end;
    logic          sh_mosi;
    logic [7:0]    sh_data;
    logic [7:0]    tx_clamp, rx_room, rx_clamp, nxt;
    logic          in_buf;

    assign in_buf    = ({1'b0, bus_addr} >= {1'b0, A_BUF_BASE}) && ({1'b0, bus_addr} < BUF_END);
    assign busy      = q.exec || (q.st != SEQ_IDLE);
    assign exec_pend = q.exec;

    spi_sclk_phase #(.DIV(DIV)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (q.st == SEQ_RUN),
        .sclk    (ph_sclk),
        .sample  (ph_sample),
        .bit_end (ph_bit_end)
    );

    spi_byte_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .load_tx  (ld_tx),
        .sample   (ph_sample),
        .bit_end  (ph_bit_end),
        .miso     (miso),
        .mosi     (sh_mosi),
        .data     (sh_data)
    );

    always_comb begin
        d         = q;
        mem_we    = 1'b0;
        mem_waddr = '0;
        mem_wdata = '0;
        ld        = 1'b0;
        ld_val    = '0;
        ld_tx     = 1'b0;
        tx_clamp  = (q.txc > DEPTH8) ? DEPTH8 : q.txc;
        rx_room   = DEPTH8 - tx_clamp;
        rx_clamp  = (q.rxc > rx_room) ? rx_room : q.rxc;
        nxt       = q.idx + 8'd1;

        // software writes
        if (bus_we) begin
            if (in_buf) begin
                mem_we    = 1'b1;
                mem_waddr = AW'(bus_addr - A_BUF_BASE);
                mem_wdata = bus_wdata;
            end else begin
                case (bus_addr)
                    A_CS_SEL: d.csel = bus_wdata[CW-1:0];
                    A_OPCODE: d.opc  = bus_wdata;
                    A_TX_CNT: d.txc  = bus_wdata;
                    A_RX_CNT: d.rxc  = bus_wdata;
                    A_CTRL_EXEC: begin
                        if (bus_wdata[0] && !busy)            d.exec = 1'b1;
                        if (bus_wdata[4] && q.st == SEQ_IDLE) d.idx  = '0;
                    end
                    default: ;
                endcase
            end
        end

        // sequencer
        case (q.st)
            SEQ_IDLE: begin
                if (q.exec) begin
                    d.exec   = 1'b0;
                    d.st     = SEQ_RUN;
                    d.cs_lat = q.csel;
                    d.tx_eff = tx_clamp;
                    d.last   = 8'd1 + tx_clamp + rx_clamp;
                    d.idx    = '0;
                    d.bitn   = '0;
                    ld       = 1'b1;
                    ld_val   = q.opc;
                    ld_tx    = 1'b1;
                end
            end
            SEQ_RUN: begin
                if (ph_bit_end) begin
                    d.bitn = q.bitn + 3'd1;
                    if (q.bitn == 3'd7) begin
                        if (q.idx > q.tx_eff) begin
                            mem_we    = 1'b1;
                            mem_waddr = AW'(q.idx - 8'd1);
                            mem_wdata = sh_data;
                        end
                        d.idx = nxt;
                        ld    = 1'b1;
                        if (nxt == q.last) begin
                            d.st  = SEQ_GAP;
                            d.gap = '0;
                        end else if (nxt <= q.tx_eff) begin
                            ld_val = mem_q[AW'(q.idx)];
                            ld_tx  = 1'b1;
                        end
                    end
                end
            end
            SEQ_GAP: begin
                if (q.gap == GW'(DIV - 1)) d.st  = SEQ_IDLE;
                else                       d.gap = q.gap + 1'b1;
            end
            default: d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (mem_we) begin
            mem_q[mem_waddr] <= mem_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (in_buf) begin
            bus_rdata = mem_q[AW'(bus_addr - A_BUF_BASE)];
        end else begin
            case (bus_addr)
                A_CTRL_EXEC: bus_rdata = {7'b0, q.exec};
                A_CTRL_STAT: bus_rdata = {busy, 7'b0};
                A_CS_SEL:    bus_rdata = 8'(q.csel);
                A_OPCODE:    bus_rdata = q.opc;
                A_TX_CNT:    bus_rdata = q.txc;
                A_RX_CNT:    bus_rdata = q.rxc;
                default:     bus_rdata = '0;
            endcase
        end
    end

    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign cs_n[g] = !((q.st == SEQ_RUN) && (q.cs_lat == CW'(g)));
    end

    assign sclk = ph_sclk;
    assign mosi = (q.st == SEQ_RUN) & sh_mosi;

endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
    parameter int NCS = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCS-1:0] cs_n,
    input logic           sclk,
    input logic           mosi,
    input logic           busy,
    input logic           exec_pend
);
    // R5: never more than one select low
    a_r5_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    // R5: select pattern does not change inside a command
    a_r5_cs_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cs_n) && $past(!(&cs_n))) |-> $stable(cs_n));

    // R3: serial clock only toggles inside a command
    a_r3_sclk_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !(&cs_n));

    // R3: data held while the clock is high
    a_r3_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R2: busy covers the active command
    a_r2_busy_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cs_n) |-> busy);

    // R2: execute request clears itself once taken
    a_r2_exec_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        exec_pend |=> !exec_pend);

    // R9: busy still high when the select lines release
    a_r9_gap_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&cs_n) |-> busy);
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.NCS(NCS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .mosi      (mosi),
    .busy      (busy),
    .exec_pend (exec_pend)
);

// File: tb/spi_cmd_engine_bench.sv
module spi_cmd_engine_bench;
    localparam int DIV = 4;
    localparam int DEPTH = 70;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h03;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sclk, mosi;
    logic       miso = 1'b0;
    logic [3:0] cs_n;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spi_cmd_engine u_spi_cmd_engine (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    // ---------------- behavioural reference ----------------
    logic [7:0] sh_buf [DEPTH];
    logic [7:0] sh_opc, sh_txc, sh_rxc;
    int         sh_cs;
    logic [7:0] m_reply [DEPTH];
    logic [7:0] m_stream [DEPTH+1];
    bit m_pend, m_act;
    int m_t, m_L, m_ntx, m_cs;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_act = 0; m_t = 0; m_L = 0;
            sh_opc = 0; sh_txc = 0; sh_rxc = 0; sh_cs = 0;
            for (int i = 0; i < DEPTH; i++) sh_buf[i] = 8'h00;
        end else begin
            bit bpre;
            bpre = m_pend || m_act;
            if (m_act) begin
                m_t++;
                if (m_t >= m_L + DIV) m_act = 0;
            end
            if (m_pend) begin
                int tx_e, rx_e;
                tx_e = (sh_txc > DEPTH) ? DEPTH : int'(sh_txc);
                rx_e = (int'(sh_rxc) > DEPTH - tx_e) ? DEPTH - tx_e : int'(sh_rxc);
                m_ntx = 1 + tx_e;
                m_L = (m_ntx + rx_e) * 8 * DIV;
                m_cs = sh_cs;
                m_stream[0] = sh_opc;
                for (int i = 0; i < tx_e; i++) m_stream[i+1] = sh_buf[i];
                for (int k = 0; k < rx_e; k++) sh_buf[tx_e+k] = m_reply[k];
                m_pend = 0; m_act = 1; m_t = 0;
            end
            if (bus_we) begin
                if (bus_addr >= 8'h80 && bus_addr < 8'h80 + DEPTH)
                    sh_buf[bus_addr - 8'h80] = bus_wdata;
                else case (bus_addr)
                    8'h1D: sh_cs = int'(bus_wdata[1:0]);
                    8'h44: sh_opc = bus_wdata;
                    8'h48: sh_txc = bus_wdata;
                    8'h4B: sh_rxc = bus_wdata;
                    8'h02: if (bus_wdata[0] && !bpre) m_pend = 1;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // slave: reply bits during receive phase, constant 1 while sending (R4)
    always @(negedge clk) begin
        if (m_act && m_t < m_L && (m_t / DIV) >= 8 * m_ntx) begin
            int j;
            j = m_t / DIV - 8 * m_ntx;
            miso <= m_reply[j/8][7 - j%8];
        end else begin
            miso <= 1'b1;
        end
    end

    // per-cycle comparison of pins and busy
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            int ecs, esclk, emosi;
            ecs = 4'hF; esclk = 0; emosi = 0;
            if (m_act && m_t < m_L) begin
                int b;
                b = m_t / DIV;
                ecs = 4'hF & ~(1 << m_cs);
                esclk = ((m_t % DIV) >= DIV/2) ? 1 : 0;
                if (b < 8 * m_ntx) emosi = int'(m_stream[b/8][7 - b%8]);
            end
            if (m_act && m_t >= m_L) chk("R9 cs_n during gap", int'(cs_n), ecs);
            else                     chk("R5 cs_n", int'(cs_n), ecs);
            chk("R3 sclk", int'(sclk), esclk);
            if (m_act && m_t < m_L && (m_t / DIV) >= 8 * m_ntx)
                chk("R4 mosi quiet while receiving", int'(mosi), emosi);
            else
                chk("R3 mosi", int'(mosi), emosi);
            if (bus_addr == 8'h03 && !bus_we)
                chk("R2 busy", int'(bus_rdata[7]), (m_pend || m_act) ? 1 : 0);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 8'h03;
    endtask

    task automatic rd(input logic [7:0] a, input int exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #2;
        chk(req, int'(bus_rdata), exp);
        bus_addr = 8'h03;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_pend || m_act) @(negedge clk);
    endtask

    task automatic set_reply(input logic [7:0] seed);
        for (int k = 0; k < DEPTH; k++) m_reply[k] = seed + 8'(k * 29);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1 cs_n", int'(cs_n), 4'hF);
        rd(8'h03, 0, "R1 busy");
        rd(8'h44, 0, "R1 opcode");
        rd(8'h48, 0, "R1 tx count");
        rd(8'h80, 0, "R1 buffer");

        // command 1: receive only, line 2
        wr(8'h1D, 8'h02); wr(8'h44, 8'h9F); wr(8'h48, 8'h00); wr(8'h4B, 8'h03);
        rd(8'h1D, 2, "R11 select");
        rd(8'h44, 8'h9F, "R11 opcode");
        rd(8'h48, 0, "R11 tx count");
        rd(8'h4B, 3, "R11 rx count");
        set_reply(8'h3C);
        wr(8'h02, 8'h01);
        bus_addr = 8'h02; #2;
        chk("R2 exec pending", int'(bus_rdata), 1);
        bus_addr = 8'h03;
        rd(8'h02, 0, "R2 exec self-clear");
        wait_idle();
        for (int i = 0; i < 3; i++) rd(8'h80 + 8'(i), int'(m_reply[i]), "R4 reply at 0");

        // command 2: send only; mid-command execute and select writes
        for (int i = 0; i < 4; i++) wr(8'h80 + 8'(i), 8'(8'h11 * (i + 1)));
        wr(8'h1D, 8'h01); wr(8'h44, 8'h02); wr(8'h48, 8'h04); wr(8'h4B, 8'h00);
        wr(8'h02, 8'h01);
        repeat (20) @(negedge clk);
        wr(8'h02, 8'h01);   // R7: ignored while busy
        wr(8'h1D, 8'h03);   // R5: latched select unaffected
        wait_idle();
        repeat (10) @(negedge clk);
        chk("R7 no second command", int'(cs_n), 4'hF);
        rd(8'h1D, 3, "R11 select rewritten");
        for (int i = 0; i < 4; i++) rd(8'h80 + 8'(i), 8'h11 * (i + 1), "R6 payload intact");

        // command 3: two out, two in
        wr(8'h1D, 8'h00); wr(8'h48, 8'h02); wr(8'h4B, 8'h02);
        set_reply(8'h81);
        wr(8'h02, 8'h01);
        wait_idle();
        rd(8'h80, 8'h11, "R4 tx byte kept");
        rd(8'h81, 8'h22, "R4 tx byte kept");
        rd(8'h82, int'(m_reply[0]), "R4 reply after tx");
        rd(8'h83, int'(m_reply[1]), "R4 reply after tx");

        // R9: back-to-back command right after busy drops
        set_reply(8'h47);
        wr(8'h02, 8'h01);
        wait_idle();
        rd(8'h82, int'(m_reply[0]), "R9 back-to-back reply");

        // R10: pointer reset bit
        wr(8'h02, 8'h10);
        rd(8'h02, 0, "R10 clear reads 0");
        repeat (8) @(negedge clk);
        rd(8'h03, 0, "R10 no command started");

        // R8: clamp, 68 out and 5 requested in
        for (int i = 0; i < DEPTH; i++) wr(8'h80 + 8'(i), 8'(i) ^ 8'h5A);
        wr(8'h48, 8'd68); wr(8'h4B, 8'd5);
        set_reply(8'hC7);
        wr(8'h02, 8'h01);
        wait_idle();
        rd(8'h80 + 8'd67, 67 ^ 8'h5A, "R8 last tx kept");
        rd(8'h80 + 8'd68, int'(m_reply[0]), "R8 reply 0");
        rd(8'h80 + 8'd69, int'(m_reply[1]), "R8 reply 1");

        // R8: transmit count above depth
        wr(8'h48, 8'd200); wr(8'h4B, 8'd9);
        wr(8'h02, 8'h01);
        wait_idle();
        rd(8'h80 + 8'd69, int'(m_reply[1]), "R8 no receive after full tx");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule